// File: doc/BRIEF.md
# Core Sleep Entry and Wake Controller

This block decides when a processor core's clock may stop for a light sleep and when it must start again. Software chooses the sleep depth with a single control bit. The core reports each wait-for-interrupt or wait-for-event instruction with a one-cycle strobe. When the depth bit is clear, such a strobe stops the core clock by dropping a clock-enable that feeds an external gate cell. Bus and peripheral clocks are never touched.

At entry the controller stores which kind of instruction put the core to sleep. Only the matching wake source can end the sleep. For an interrupt-type entry this is any pending interrupt line. For an event-type entry it is the wakeup-event input. Wake does not run any interrupt entry or exit sequence: the clock-enable is simply raised again on the next cycle.

When the depth bit is set, the core is not gated. Instead, a one-cycle request is passed to the deeper power logic downstream.

Top module: `slp_wake_ctl`

## Requirements
- R1: After reset, core_clk_en is 1, sleeping is 0 and deep_req is 0.
- R2: While running with depth_sel = 0, a wfi_stb or wfe_stb drops core_clk_en and raises sleeping on the next cycle, unless R7 applies.
- R3: sleeping is always the inverse of core_clk_en.
- R4: After an entry through wfi_stb, any set bit of irq_pend restores core_clk_en on the next cycle. wake_evt alone does not wake the core.
- R5: After an entry through wfe_stb, wake_evt restores core_clk_en on the next cycle. irq_pend alone does not wake the core.
- R6: While running with depth_sel = 1, a strobe leaves core_clk_en at 1. deep_req is 1 on the next cycle only and returns to 0 on the cycle after that.
- R7: If the wake source for the entering instruction is already present in the strobe cycle, entry is cancelled and core_clk_en stays 1. For wfi_stb that source is any bit of irq_pend. For wfe_stb it is wake_evt.
- R8: Strobes that arrive while sleeping are ignored. They do not pulse deep_req and do not change the stored wake source.
- R9: When wfi_stb and wfe_stb arrive together, the entry is treated as interrupt-type.
- R10: deep_req is 1 only in the cycle after a running-state strobe seen with depth_sel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the controller |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 1 | Sleep-depth control bit: 0 selects light sleep, 1 selects a deep-sleep request |
| wfi_stb | input | 1 | One-cycle strobe for a wait-for-interrupt instruction |
| wfe_stb | input | 1 | One-cycle strobe for a wait-for-event instruction |
| irq_pend | input | NIRQ | Pending interrupt lines |
| wake_evt | input | 1 | Wakeup-event line |
| core_clk_en | output | 1 | Enable for the core clock gate |
| sleeping | output | 1 | High while the core clock is stopped |
| deep_req | output | 1 | One-cycle request to the deep-sleep logic |

## Verification
All state is visible at the ports within one cycle. A wrong sleep flag shows up on core_clk_en and sleeping one cycle after the strobe or wake input that set it. A wrong stored wake source stays hidden while the core sleeps. It appears only when the wrong source is offered and the core wakes on it, or when the right source is offered and the core does not wake. For that reason the tests present the non-matching source first and the matching one after it. They also send a strobe during sleep to try to overwrite the stored source.

// File: rtl/slp_wake_ctl.sv
`timescale 1ns/1ps
module slp_wake_ctl #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            depth_sel,
  input  logic            wfi_stb,
  input  logic            wfe_stb,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            wake_evt,
  output logic            core_clk_en,
  output logic            sleeping,
  output logic            deep_req
);
  logic asleep_q, cause_evt_q, deep_q;
  logic any_irq, strobe, new_evt, entry_wake, held_wake;
  logic go_sleep, go_deep, go_wake;

  assign any_irq    = |irq_pend;
  assign strobe     = wfi_stb | wfe_stb;
  assign new_evt    = ~wfi_stb;
  assign entry_wake = new_evt ? wake_evt : any_irq;
  assign held_wake  = cause_evt_q ? wake_evt : any_irq;

  assign go_sleep = ~asleep_q & strobe & ~depth_sel & ~entry_wake;
  assign go_deep  = ~asleep_q & strobe & depth_sel;
  assign go_wake  = asleep_q & held_wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep_q    <= 1'b0;
      cause_evt_q <= 1'b0;
      deep_q      <= 1'b0;
    end else begin
      deep_q <= go_deep;
      if (go_sleep) begin
        asleep_q    <= 1'b1;
        cause_evt_q <= new_evt;
      end else if (go_wake) begin
        asleep_q <= 1'b0;
      end
    end
  end

  assign core_clk_en = ~asleep_q;
  assign sleeping    = asleep_q;
  assign deep_req    = deep_q;
endmodule

module slp_wake_ctl_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            depth_sel,
  input logic            wfi_stb,
  input logic            wfe_stb,
  input logic [NIRQ-1:0] irq_pend,
  input logic            wake_evt,
  input logic            core_clk_en,
  input logic            sleeping,
  input logic            deep_req,
  input logic            cause_evt
);
  a_r3_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping != core_clk_en);

  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !depth_sel && wfi_stb && ~|irq_pend) |=> sleeping);

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfi_stb && |irq_pend) |=> !sleeping);

  a_r4_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !cause_evt && |irq_pend) |=> !sleeping);

  a_r5_evt_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && cause_evt && wake_evt) |=> !sleeping);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !(cause_evt ? wake_evt : |irq_pend)) |=> (sleeping && $stable(cause_evt)));

  a_r6_deep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && depth_sel && (wfi_stb || wfe_stb)) |=> (deep_req && !sleeping));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    deep_req |=> !deep_req);

  a_r10_deep_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_req) |-> $past(!sleeping && depth_sel && (wfi_stb || wfe_stb)));
endmodule

bind slp_wake_ctl slp_wake_ctl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .wfi_stb(wfi_stb),
  .wfe_stb(wfe_stb), .irq_pend(irq_pend), .wake_evt(wake_evt),
  .core_clk_en(core_clk_en), .sleeping(sleeping), .deep_req(deep_req),
  .cause_evt(cause_evt_q)
);

// File: tb/slp_wake_ctl_bench.sv
`timescale 1ns/1ps
module slp_wake_ctl_bench;
  localparam int NIRQ = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic depth_sel = 1'b0, wfi_stb = 1'b0, wfe_stb = 1'b0, wake_evt = 1'b0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic core_clk_en, sleeping, deep_req;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slp_wake_ctl #(.NIRQ(NIRQ)) u_slp_wake_ctl (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .wfi_stb(wfi_stb),
    .wfe_stb(wfe_stb), .irq_pend(irq_pend), .wake_evt(wake_evt),
    .core_clk_en(core_clk_en), .sleeping(sleeping), .deep_req(deep_req));

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wfi_stb = 0; wfe_stb = 0; wake_evt = 0; irq_pend = '0; depth_sel = 0;
  endtask

  task automatic state(string req, logic en);
    chk(req, "core_clk_en", core_clk_en, en);
    chk("R3", "sleeping", sleeping, ~en);
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); step(); step();
    state("R1", 1'b1);
    chk("R1", "deep_req", deep_req, 1'b0);
    rst_n = 1; step();
    state("R1", 1'b1);
  endtask

  task automatic t_wfi();
    wfi_stb = 1; step(); idle();
    state("R2", 1'b0);
    wake_evt = 1; step(); wake_evt = 0;
    state("R4", 1'b0);
    irq_pend = 8'h20; step(); idle();
    state("R4", 1'b1);
  endtask

  task automatic t_wfe();
    wfe_stb = 1; irq_pend = '0; step(); idle();
    state("R2", 1'b0);
    irq_pend = 8'h01; step(); idle(); step();
    state("R5", 1'b0);
    wake_evt = 1; step(); idle();
    state("R5", 1'b1);
  endtask

  task automatic t_deep();
    depth_sel = 1; wfe_stb = 1; step(); idle(); depth_sel = 1;
    chk("R6", "deep_req pulse", deep_req, 1'b1);
    state("R6", 1'b1);
    step();
    chk("R6", "deep_req clear", deep_req, 1'b0);
    state("R6", 1'b1);
    step();
    chk("R10", "deep_req idle", deep_req, 1'b0);
    idle();
  endtask

  task automatic t_cancel();
    wfi_stb = 1; irq_pend = 8'h80; step(); idle();
    state("R7", 1'b1);
    wfe_stb = 1; wake_evt = 1; step(); idle();
    state("R7", 1'b1);
    wfi_stb = 1; wake_evt = 1; step(); idle();
    state("R7", 1'b0);
    irq_pend = 8'h02; step(); idle();
    state("R4", 1'b1);
  endtask

  task automatic t_ignore();
    wfe_stb = 1; step(); idle();
    state("R8", 1'b0);
    depth_sel = 1; wfi_stb = 1; step(); idle();
    chk("R8", "deep_req while asleep", deep_req, 1'b0);
    state("R8", 1'b0);
    wfi_stb = 1; step(); idle();
    irq_pend = 8'h10; step(); idle();
    state("R8", 1'b0);
    wake_evt = 1; step(); idle();
    state("R8", 1'b1);
  endtask

  task automatic t_both();
    wfi_stb = 1; wfe_stb = 1; step(); idle();
    state("R9", 1'b0);
    wake_evt = 1; step(); idle();
    state("R9", 1'b0);
    irq_pend = 8'h04; step(); idle();
    state("R9", 1'b1);
  endtask

  initial begin
    t_reset();
    t_wfi();
    t_wfe();
    t_deep();
    t_cancel();
    t_ignore();
    t_both();
    step();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule